// File: doc/BRIEF.md
# Delay-Addressed Serial Register Bank

This block holds sixty-four 16-bit words. Each word lives in its own bit-serial loop that rotates by one position on every clock, whether or not anything is accessing the bank. No binary decoder picks a register. Instead, a select path is modelled as a column of cells, one per register, and pulses move through it one cell per clock. To pick a register, an "up" train of 16 pulses is launched first. It climbs an outer line, is turned round at the top, and comes back down. A second train of 16 pulses is launched up an inner line a chosen number of cycles later. Where the two trains meet, they annihilate each other, and that cell is the one selected for the 16 cycles in which the pulse pairs meet.

Reads and writes each have their own select column. On a read, the selected loop drops its bits, one per meeting, into a serial chain that carries them down to the bottom port. The trip through the chain balances the trip of the trains, so the read latency is the same for every register. On a write, a data line enters at the top of the bank and runs down to the selected loop. There an OR term sets the passing bit and an AND-NOT term clears it.

A small sequencer is included for testing. It turns a register number into a launch delay of 2*(63-k) cycles. It also waits until the loops' shared rotation phase lines up so that bit 0 is handled first.

The sequencer is one state machine, used once for reads and once for writes. It has these states:
- IDLE: waits for a request. A request moves it to ALIGN.
- ALIGN: waits until the next cycle's rotation phase equals the target phase for the register. It then moves to FIRE.
- FIRE: launches the outer train for 16 cycles, then moves to TRAVEL.
- TRAVEL: launches the delayed inner train and lets both trains drain. After a fixed count it returns to IDLE.

Top module: `rb_delay_bank`

## Requirements
- R1: After reset every register reads as 0x0000, and rd_busy, wr_busy, rd_launch, rd_valid and rd_bit are all 0.
- R2: A read returns the word last written to that register, serially on rd_bit. The first cycle with rd_valid high carries bit 0 and the last carries bit 15.
- R3: Register k is selected only where the two trains meet, using a launch delay of 2*(63-k) cycles. At most one cell of each select column is active per cycle, and a write to register k leaves all other registers unchanged.
- R4: The first rd_valid cycle comes exactly 128 cycles (twice the register count) after the first rd_launch cycle, for every register.
- R5: rd_valid is high for exactly 16 consecutive cycles per read, and only while rd_busy is high.
- R6: rd_launch, the outer read train, is high for exactly 16 consecutive cycles per read. The write data line only reaches a loop while a write is running.
- R7: A read or write request that arrives while that side is busy is ignored. Its register number and data have no effect.
- R8: Stored words survive any number of idle cycles, because the loops keep rotating without losing bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request, taken when rd_busy is low |
| rd_reg | input | 6 | Register number for the read |
| rd_busy | output | 1 | Read sequencer is not IDLE |
| rd_launch | output | 1 | Outer read train pulse |
| rd_valid | output | 1 | rd_bit carries a data bit |
| rd_bit | output | 1 | Serial read data, LSB first |
| wr_req | input | 1 | Write request, taken when wr_busy is low |
| wr_reg | input | 6 | Register number for the write |
| wr_data | input | 16 | Word to write, captured with the request |
| wr_busy | output | 1 | Write sequencer is not IDLE |

## Verification
A read's data bits are due 128 cycles after the first rd_launch cycle. They then arrive one per cycle for 16 cycles. The alignment wait before rd_launch varies from 0 to 15 cycles, so the bench times everything from the rd_launch rise it observes, not from the request. The bench samples every output at the falling edge. It records the cycle of the first launch and of the first and last valid bits, and checks the latency, the length of the valid run and its contiguity against these fixed numbers. A write's effect can only be seen once wr_busy has fallen, so each write is checked by a read issued after that. The reference array is updated only for requests issued while the side was idle.

// File: rtl/rb_pkg.sv
package rb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ALIGN  = 2'd1,
        ST_FIRE   = 2'd2,
        ST_TRAVEL = 2'd3
    } rb_state_e;
endpackage

// File: rtl/rb_sel_chain.sv
// Column of select cells: an outer train climbs, turns at the top and
// descends; a delayed inner train climbs; meeting pulses annihilate and
// mark the selected cell for that cycle.
module rb_sel_chain #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         launch_out,
    input  logic         launch_in,
    output logic [N-1:0] hit
);
    logic [N-2:0] up_o;
    logic [N-1:0] dn;
    logic [N-1:0] up_i;

    assign hit = dn & up_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_o <= '0;
            dn   <= '0;
            up_i <= '0;
        end else begin
            up_o <= {up_o[N-3:0], launch_out};
            dn   <= {up_o[N-2], dn[N-1:1] & ~up_i[N-1:1]};
            up_i <= {up_i[N-2:0] & ~dn[N-2:0], launch_in};
        end
    end

    // R3: the trains meet in at most one cell per cycle
    a_r3_single_meet: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: rtl/rb_stub.sv
// Sequencer: turns a register number into a launch delay and aligns the
// launch with the loop rotation so that bit 0 is handled first.
module rb_stub
    import rb_pkg::*;
#(
    parameter int N  = 64,
    parameter int W  = 16,
    localparam int AW   = $clog2(N),
    localparam int PW   = $clog2(W),
    localparam int LAST = 3 * N + 2 * W,
    localparam int CW   = $clog2(LAST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] reg_idx,
    input  logic [PW-1:0] ph,
    output logic          busy,
    output logic          launch_out,
    output logic          launch_in,
    output logic          run,
    output logic [CW-1:0] tick
);
    rb_state_e     state_q, state_d;
    logic [AW-1:0] k_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] dly;
    logic [PW-1:0] tgt;
    logic          aligned;

    always_comb begin
        dly     = (CW'(N - 1) - CW'(k_q)) << 1;
        tgt     = PW'(k_q) + PW'(1) - PW'(2 * N);
        aligned = (ph + PW'(1)) == tgt;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req)                       state_d = ST_ALIGN;
            ST_ALIGN:  if (aligned)                   state_d = ST_FIRE;
            ST_FIRE:   if (cnt_q == CW'(W - 1))       state_d = ST_TRAVEL;
            ST_TRAVEL: if (cnt_q == CW'(LAST))        state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            k_q     <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req) k_q <= reg_idx;
            if (state_q == ST_ALIGN) cnt_q <= '0;
            else if (run)            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        busy       = (state_q != ST_IDLE);
        launch_out = (state_q == ST_FIRE);
        run        = (state_q == ST_FIRE) || (state_q == ST_TRAVEL);
        launch_in  = run && (cnt_q >= dly) && (cnt_q < dly + CW'(W));
        tick       = cnt_q;
    end

    // R7: the register number is frozen while a request is in flight
    a_r7_hold_idx: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(k_q));
endmodule

// File: rtl/rb_store.sv
// Recirculating loops, read chain (toward the bottom port) and write data
// chain (from the top), plus the shared rotation phase.
module rb_store #(
    parameter int N  = 64,
    parameter int W  = 16,
    localparam int PW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  rhit,
    input  logic [N-1:0]  whit,
    input  logic          wd_line,
    output logic [PW-1:0] ph,
    output logic          rd_line
);
    logic [W-1:0]  loop_q [N];
    logic [N-1:0]  rchain;
    logic [N-1:0]  dchain;
    logic [N-1:0]  tap;
    logic [N-1:0]  nbit;
    logic [PW-1:0] ph_q;

    always_comb begin
        for (int j = 0; j < N; j++) begin
            tap[j]  = loop_q[j][0];
            nbit[j] = (tap[j] | (whit[j] & dchain[j])) & ~(whit[j] & ~dchain[j]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < N; j++) loop_q[j] <= '0;
            rchain <= '0;
            dchain <= '0;
            ph_q   <= '0;
        end else begin
            for (int j = 0; j < N; j++) loop_q[j] <= {nbit[j], loop_q[j][W-1:1]};
            rchain <= {1'b0, rchain[N-1:1]} | (rhit & tap);
            dchain <= {wd_line, dchain[N-1:1]};
            ph_q   <= ph_q + PW'(1);
        end
    end

    assign ph      = ph_q;
    assign rd_line = rchain[0];

    // R3: at most one loop is written per cycle
    a_r3_one_write_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(whit));
endmodule

// File: rtl/rb_delay_bank.sv
module rb_delay_bank #(
    parameter int N  = 64,
    parameter int W  = 16,
    localparam int AW   = $clog2(N),
    localparam int PW   = $clog2(W),
    localparam int LAST = 3 * N + 2 * W,
    localparam int CW   = $clog2(LAST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_reg,
    output logic          rd_busy,
    output logic          rd_launch,
    output logic          rd_valid,
    output logic          rd_bit,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_reg,
    input  logic [W-1:0]  wr_data,
    output logic          wr_busy
);
    logic          r_lin, r_run, w_lout, w_lin, w_run;
    logic [CW-1:0] rtick, wtick;
    logic [N-1:0]  rhit, whit;
    logic [PW-1:0] ph;
    logic [PW-1:0] woff;
    logic [W-1:0]  wword_q;
    logic          wd_line, rd_line;

    rb_stub #(.N(N), .W(W)) u_rstub (
        .clk(clk), .rst_n(rst_n), .req(rd_req), .reg_idx(rd_reg), .ph(ph),
        .busy(rd_busy), .launch_out(rd_launch), .launch_in(r_lin),
        .run(r_run), .tick(rtick));

    rb_stub #(.N(N), .W(W)) u_wstub (
        .clk(clk), .rst_n(rst_n), .req(wr_req), .reg_idx(wr_reg), .ph(ph),
        .busy(wr_busy), .launch_out(w_lout), .launch_in(w_lin),
        .run(w_run), .tick(wtick));

    rb_sel_chain #(.N(N)) u_rsel (
        .clk(clk), .rst_n(rst_n), .launch_out(rd_launch), .launch_in(r_lin),
        .hit(rhit));

    rb_sel_chain #(.N(N)) u_wsel (
        .clk(clk), .rst_n(rst_n), .launch_out(w_lout), .launch_in(w_lin),
        .hit(whit));

    rb_store #(.N(N), .W(W)) u_store (
        .clk(clk), .rst_n(rst_n), .rhit(rhit), .whit(whit),
        .wd_line(wd_line), .ph(ph), .rd_line(rd_line));

    always_ff @(posedge clk) begin
        if (!rst_n)                  wword_q <= '0;
        else if (wr_req && !wr_busy) wword_q <= wr_data;
    end

    // data bit i enters the top N-1+i cycles after the outer write train
    always_comb begin
        woff    = PW'(wtick - CW'(N - 1));
        wd_line = w_run && (wtick >= CW'(N - 1)) && (wtick < CW'(N - 1 + W))
                  && wword_q[woff];
        rd_valid = r_run && (rtick >= CW'(2 * N)) && (rtick < CW'(2 * N + W));
        rd_bit   = rd_line;
    end

    // R5: data are only presented during a read
    a_r5_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_busy);
    // R4: read cells are only selected while the read trains run
    a_r4_hit_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (|rhit) |-> r_run);
    // R6: loops are only written while a write runs
    a_r6_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (|whit) |-> w_run);
    // R6: once started, the outer read train continues
    a_r6_train_cont: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_launch) |=> rd_launch);
endmodule

// File: tb/sim_rb_delay_bank.sv
module sim_rb_delay_bank;
    localparam int CLK_P = 10;
    localparam int N = 64;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_req = 1'b0, wr_req = 1'b0;
    logic [5:0] rd_reg = '0, wr_reg = '0;
    logic [15:0] wr_data = '0;
    logic rd_busy, rd_launch, rd_valid, rd_bit, wr_busy;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    logic [15:0] ref_mem [N];

    always #(CLK_P / 2) clk = ~clk;

    rb_delay_bank u0 (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_reg(rd_reg),
        .rd_busy(rd_busy), .rd_launch(rd_launch), .rd_valid(rd_valid),
        .rd_bit(rd_bit), .wr_req(wr_req), .wr_reg(wr_reg), .wr_data(wr_data),
        .wr_busy(wr_busy));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    function automatic logic [15:0] pat(input int k);
        return 16'((k * 40503) ^ 16'h5A3C ^ (k << 10));
    endfunction

    task automatic do_write(input int k, input logic [15:0] d);
        @(negedge clk);
        wr_req = 1'b1; wr_reg = 6'(k); wr_data = d;
        @(negedge clk);
        wr_req = 1'b0;
        while (wr_busy) @(negedge clk);
        ref_mem[k] = d;
    endtask

    // read register k and check the word, latency and train shapes
    task automatic do_read(input int k, input bit poke);
        logic [15:0] w;
        int t, t0, tv, tl, nv, nl;
        w = '0; t = 0; t0 = -1; tv = -1; tl = -1; nv = 0; nl = 0;
        @(negedge clk);
        rd_req = 1'b1; rd_reg = 6'(k);
        @(negedge clk);
        // R7: a second request while busy, naming another register
        rd_req = poke; rd_reg = 6'(k ^ 1);
        while (rd_busy) begin
            if (t == 1) rd_req = 1'b0;
            if (rd_launch) begin
                if (t0 < 0) t0 = t;
                nl++;
            end
            if (rd_valid) begin
                if (tv < 0) tv = t;
                tl = t;
                if (nv < W) w[nv] = rd_bit;
                nv++;
            end
            @(negedge clk);
            t++;
        end
        rd_req = 1'b0;
        chk(w == ref_mem[k], $sformatf("R2 R3 read word reg %0d", k), w, ref_mem[k]);
        chk(tv - t0 == 2 * N, $sformatf("R4 latency reg %0d", k), tv - t0, 2 * N);
        chk(nv == W && tl - tv == W - 1, $sformatf("R5 valid run reg %0d", k), nv, W);
        chk(nl == W, $sformatf("R6 launch length reg %0d", k), nl, W);
    endtask

    initial begin
        for (int i = 0; i < N; i++) ref_mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!rd_busy && !wr_busy, "R1 busy after reset", {rd_busy, wr_busy}, 0);
        chk(!rd_valid && !rd_bit && !rd_launch, "R1 read port idle after reset",
            {rd_valid, rd_bit, rd_launch}, 0);
        do_read(0, 1'b0);
        do_read(37, 1'b0);
        do_read(63, 1'b0);

        // R3 sweep: distinct word in every register, then read all
        for (int k = 0; k < N; k++) do_write(k, pat(k));
        for (int k = 0; k < N; k++) do_read(k, 1'b0);

        // R2 edge patterns, bit order
        do_write(5, 16'h0001); do_read(5, 1'b0);
        do_write(5, 16'h8000); do_read(5, 1'b0);
        do_write(5, 16'hFFFF); do_read(5, 1'b0);
        do_write(5, 16'h0000); do_read(5, 1'b0);
        do_read(4, 1'b0); do_read(6, 1'b0);

        // R7 write request while busy is ignored
        @(negedge clk);
        wr_req = 1'b1; wr_reg = 6'd10; wr_data = 16'h1234;
        @(negedge clk);
        wr_reg = 6'd11; wr_data = 16'hBEEF;
        @(negedge clk);
        wr_req = 1'b0;
        while (wr_busy) @(negedge clk);
        ref_mem[10] = 16'h1234;
        do_read(10, 1'b0);
        do_read(11, 1'b0);
        // R7 read request while busy is ignored (one word only)
        do_read(20, 1'b1);

        // random writes and reads
        for (int i = 0; i < 60; i++) begin
            int k;
            logic [15:0] d;
            k = int'($urandom_range(0, N - 1));
            d = 16'($urandom);
            do_write(k, d);
            do_read(int'($urandom_range(0, N - 1)), 1'b0);
            do_read(k, 1'b0);
        end

        // R8 retention over a long idle gap
        repeat (777) @(negedge clk);
        for (int k = 0; k < N; k += 3) do_read(k, 1'b0);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end
endmodule